// File: doc/BRIEF.md
# Self-Checking Carry-Select Adder with Parity and Dual Rails

This block adds two 64-bit operands and checks its own result while it works. Each operand arrives with one parity bit, the XOR of all of its bits. A single set of propagate terms (bitwise XOR of the operands) is built once and shared by every adder segment. The XOR of those terms is compared with the XOR of the two incoming parity bits, so one parity tree checks both the operands and the shared propagate terms.

The word is cut into segments of 8, 8, 12, 12, 12 and 12 bits, starting from bit 0. The lowest segment is built once with carry-in 0. Every higher segment is built twice, once assuming carry-in 0 and once assuming carry-in 1. Each segment copy forms a true sum rail and an inverted sum rail from two independent carry chains, so it yields two copies of its carry-out. The two carry copies from the segment below drive separate multiplexers: copy 1 selects the sum rail and the copy-1 carry, and copy 2 selects the inverted rail and the copy-2 carry. The two carry copies therefore stay independent all the way to bit 63.

An error flag rises if the parity comparison fails, if any sum bit equals its inverted bit, or if the two final carries disagree. The results pass through an optional output register (on by default) with a synchronous active-high reset.

Top module: `scsa_adder`

## Requirements
- R1: With the output register enabled, `sum_o` equals the low 64 bits of `a_i + b_i`, taken from the operands present at the previous rising clock edge.
- R2: When no fault is present, `sumn_o` is the bitwise inverse of `sum_o`.
- R3: When no fault is present, `cout1_o` and `cout2_o` both equal the carry out of bit 63 of `a_i + b_i`.
- R4: `err_o` is 1 when `pa_i XOR pb_i` differs from the XOR of all 64 bits of `a_i XOR b_i`. Here `pa_i` is the parity of `a_i` and `pb_i` is the parity of `b_i`.
- R5: `err_o` is 1 when any bit of the internal sum rail equals the same bit of the internal inverted rail.
- R6: `err_o` is 1 when the two final carry copies differ.
- R7: Carries cross every segment boundary (bits 8, 16, 28, 40 and 52) correctly. Operand pairs whose carry ripples up to or across a boundary give the exact sum.
- R8: A single inverted bit in the shared propagate vector makes `err_o` 1.
- R9: A synchronous reset (`rst` = 1 at a rising edge) sets `sum_o` to 0, `sumn_o` to all ones, both carries to 0 and `err_o` to 0.
- R10: The registered outputs change only at a rising clock edge. An operand change between edges does not reach the outputs before the next edge.
- R11: When the operands and parity bits are consistent and no fault is present, `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| pa_i | input | 1 | Parity (XOR of all bits) of `a_i` |
| pb_i | input | 1 | Parity (XOR of all bits) of `b_i` |
| sum_o | output | 64 | Sum rail |
| sumn_o | output | 64 | Inverted sum rail |
| cout1_o | output | 1 | Carry-out, copy 1 |
| cout2_o | output | 1 | Carry-out, copy 2 |
| err_o | output | 1 | Self-check error flag |

## Verification
On every cycle outside reset, the assertions check the combinational core against its own inputs. Whenever the error flag is low, the sum must match a reference addition, the inverted rail must mirror the sum rail, and both carry copies must equal the true carry. A parity mismatch at the inputs must always raise the flag, and the first cycle after reset must show the reset values. Only the bench scenarios show that the flag actually rises under injected internal faults: a flipped propagate bit, a flipped sum-rail bit, a flipped inverted-rail bit and a broken carry copy. The same applies to carries crossing each segment boundary and to the one-cycle output timing.

// File: rtl/scsa_pkg.sv
package scsa_pkg;

    localparam int unsigned DATA_W  = 64;
    localparam int unsigned SEG_CNT = 6;
    localparam int unsigned SEG0_W  = 8;
    localparam int unsigned SEG1_W  = 8;
    localparam int unsigned SEGN_W  = 12;

    // Width of segment k: two leading sizes, then a repeated size.
    function automatic int unsigned seg_width(int unsigned k, int unsigned w0,
                                              int unsigned w1, int unsigned wn);
        if (k == 0)
            return w0;
        else if (k == 1)
            return w1;
        return wn;
    endfunction

    // Lowest bit index of segment k.
    function automatic int unsigned seg_base(int unsigned k, int unsigned w0,
                                             int unsigned w1, int unsigned wn);
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < k; i++)
            acc += seg_width(i, w0, w1, wn);
        return acc;
    endfunction

endpackage

// File: rtl/scsa_rail_seg.sv
// One adder segment with a fixed carry-in. The true rail uses a generate
// chain. The inverted rail uses an independent kill-based chain, so both
// the sum rail and the carry-out come out in two independent copies.
module scsa_rail_seg #(
    parameter int unsigned W   = 8,
    parameter logic        CIN = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] sumn_o,
    output logic         co1_o,
    output logic         co2_o
);
    logic [W-1:0] gen_w;
    logic [W-1:0] kil_w;
    logic [W:0]   cy_w;     // true carries
    logic [W:0]   cyn_w;    // inverted carries, separate chain

    assign gen_w    = a_i & b_i;
    assign kil_w    = ~(a_i | b_i);
    assign cy_w[0]  = CIN;
    assign cyn_w[0] = ~CIN;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign cy_w[i+1]  = gen_w[i] | (p_i[i] & cy_w[i]);
        assign cyn_w[i+1] = kil_w[i] | (p_i[i] & cyn_w[i]);
        assign sum_o[i]   = p_i[i] ^ cy_w[i];
        assign sumn_o[i]  = p_i[i] ^ cyn_w[i];
    end

    assign co1_o = cy_w[W];
    assign co2_o = ~cyn_w[W];

endmodule

// File: rtl/scsa_sel_seg.sv
// A duplicated segment: one copy per carry-in value. Carry copy 1 from below
// steers the sum rail and the copy-1 carry. Carry copy 2 steers the inverted
// rail and the copy-2 carry.
module scsa_sel_seg #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] p_i,
    input  logic         cin1_i,
    input  logic         cin2_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] sumn_o,
    output logic         co1_o,
    output logic         co2_o
);
    logic [W-1:0] sum_z, sumn_z, sum_o1, sumn_o1;
    logic         c1_z, c2_z, c1_o1, c2_o1;

    scsa_rail_seg #(.W(W), .CIN(1'b0)) u_cin_zero (
        .a_i(a_i), .b_i(b_i), .p_i(p_i),
        .sum_o(sum_z), .sumn_o(sumn_z), .co1_o(c1_z), .co2_o(c2_z)
    );

    scsa_rail_seg #(.W(W), .CIN(1'b1)) u_cin_one (
        .a_i(a_i), .b_i(b_i), .p_i(p_i),
        .sum_o(sum_o1), .sumn_o(sumn_o1), .co1_o(c1_o1), .co2_o(c2_o1)
    );

    always_comb begin
        sum_o  = cin1_i ? sum_o1  : sum_z;
        co1_o  = cin1_i ? c1_o1   : c1_z;
        sumn_o = cin2_i ? sumn_o1 : sumn_z;
        co2_o  = cin2_i ? c2_o1   : c2_z;
    end

endmodule

// File: rtl/scsa_check.sv
// Error detector: parity of the shared propagate terms against the input
// parity, rail complementarity, and agreement of the two carry copies.
module scsa_check #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] prop_i,
    input  logic         pa_i,
    input  logic         pb_i,
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] sumn_i,
    input  logic         c1_i,
    input  logic         c2_i,
    output logic         err_o
);
    logic par_bad, rail_bad, cy_bad;

    always_comb begin
        par_bad  = (^prop_i) ^ (pa_i ^ pb_i);
        rail_bad = |(~(sum_i ^ sumn_i));
        cy_bad   = c1_i ^ c2_i;
        err_o    = par_bad | rail_bad | cy_bad;
    end

endmodule

// File: rtl/scsa_adder.sv
module scsa_adder
    import scsa_pkg::*;
#(
    parameter int unsigned DW      = scsa_pkg::DATA_W,
    parameter int unsigned NSEG    = scsa_pkg::SEG_CNT,
    parameter int unsigned W_FIRST = scsa_pkg::SEG0_W,
    parameter int unsigned W_SEC   = scsa_pkg::SEG1_W,
    parameter int unsigned W_REST  = scsa_pkg::SEGN_W,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          pa_i,
    input  logic          pb_i,
    output logic [DW-1:0] sum_o,
    output logic [DW-1:0] sumn_o,
    output logic          cout1_o,
    output logic          cout2_o,
    output logic          err_o
);
    localparam int unsigned SPAN_W = seg_base(NSEG, W_FIRST, W_SEC, W_REST);

    typedef struct packed {
        logic [DW-1:0] sum;
        logic [DW-1:0] sumn;
        logic          cy1;
        logic          cy2;
        logic          err;
    } res_t;

    if (SPAN_W != DW) begin : g_bad_split
        $error("segment widths do not add up to the data width");
    end

    logic [DW-1:0]   prop_w;
    logic [DW-1:0]   sum_w;
    logic [DW-1:0]   sumn_w;
    logic [NSEG-1:0] cy1_seg;
    logic [NSEG-1:0] cy2_seg;
    logic            cout1_w;
    logic            cout2_w;
    logic            err_w;
    res_t            res_c;
    res_t            res_q;

    // Shared propagate terms, built once for all segments and both copies.
    assign prop_w = a_i ^ b_i;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int unsigned LO = seg_base(k, W_FIRST, W_SEC, W_REST);
        localparam int unsigned SW = seg_width(k, W_FIRST, W_SEC, W_REST);
        if (k == 0) begin : g_base
            scsa_rail_seg #(.W(SW), .CIN(1'b0)) u_base (
                .a_i(a_i[LO +: SW]), .b_i(b_i[LO +: SW]), .p_i(prop_w[LO +: SW]),
                .sum_o(sum_w[LO +: SW]), .sumn_o(sumn_w[LO +: SW]),
                .co1_o(cy1_seg[k]), .co2_o(cy2_seg[k])
            );
        end else begin : g_dup
            scsa_sel_seg #(.W(SW)) u_sel (
                .a_i(a_i[LO +: SW]), .b_i(b_i[LO +: SW]), .p_i(prop_w[LO +: SW]),
                .cin1_i(cy1_seg[k-1]), .cin2_i(cy2_seg[k-1]),
                .sum_o(sum_w[LO +: SW]), .sumn_o(sumn_w[LO +: SW]),
                .co1_o(cy1_seg[k]), .co2_o(cy2_seg[k])
            );
        end
    end

    assign cout1_w = cy1_seg[NSEG-1];
    assign cout2_w = cy2_seg[NSEG-1];

    scsa_check #(.W(DW)) u_check (
        .prop_i(prop_w), .pa_i(pa_i), .pb_i(pb_i),
        .sum_i(sum_w), .sumn_i(sumn_w),
        .c1_i(cout1_w), .c2_i(cout2_w),
        .err_o(err_w)
    );

    always_comb begin
        res_c.sum  = sum_w;
        res_c.sumn = sumn_w;
        res_c.cy1  = cout1_w;
        res_c.cy2  = cout2_w;
        res_c.err  = err_w;
    end

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q.sum  <= '0;
                res_q.sumn <= '1;
                res_q.cy1  <= 1'b0;
                res_q.cy2  <= 1'b0;
                res_q.err  <= 1'b0;
            end else begin
                res_q <= res_c;
            end
        end

        assert_reset_vals_R9: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (sum_o == '0 && sumn_o == '1 && !cout1_o && !cout2_o && !err_o));
    end else begin : g_comb
        assign res_q = res_c;
    end

    assign sum_o   = res_q.sum;
    assign sumn_o  = res_q.sumn;
    assign cout1_o = res_q.cy1;
    assign cout2_o = res_q.cy2;
    assign err_o   = res_q.err;

    // Reference addition used only by the checks below.
    logic [DW:0] ref_add;
    assign ref_add = {1'b0, a_i} + {1'b0, b_i};

    assert_sum_ok_R1: assert property (@(posedge clk) disable iff (rst)
        !err_w |-> (sum_w == ref_add[DW-1:0]));

    assert_rails_R2: assert property (@(posedge clk) disable iff (rst)
        !err_w |-> (sumn_w == ~sum_w));

    assert_carry_pair_R3: assert property (@(posedge clk) disable iff (rst)
        !err_w |-> (cout1_w == ref_add[DW] && cout2_w == ref_add[DW]));

    assert_parity_flag_R4: assert property (@(posedge clk) disable iff (rst)
        ((pa_i ^ pb_i) != (^a_i ^ ^b_i)) |-> err_w);

endmodule

// File: tb/scsa_adder_bench.sv
module scsa_adder_bench;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic         pa = 1'b0, pb = 1'b0;
    logic [W-1:0] sum, sumn;
    logic         c1, c2, err;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [W-1:0] fv;
    logic         fb;

    always #5 clk = ~clk;

    scsa_adder u_scsa_adder (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .pa_i(pa), .pb_i(pb),
        .sum_o(sum), .sumn_o(sumn), .cout1_o(c1), .cout2_o(c2), .err_o(err)
    );

    function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic bad);
        @(negedge clk);
        a  = x;
        b  = y;
        pa = ^x;
        pb = (^y) ^ bad;
    endtask

    // Outputs checked one edge after the operands are applied.
    task automatic check_result(string tag, logic [W-1:0] x, logic [W-1:0] y, logic bad);
        logic [W:0] r;
        r = ref_add(x, y);
        chk(tag, "sum", sum, r[W-1:0]);
        chk(tag, "sumn", sumn, ~r[W-1:0]);
        chk(tag, "cout1", {63'd0, c1}, {63'd0, r[W]});
        chk(tag, "cout2", {63'd0, c2}, {63'd0, r[W]});
        chk(tag, "err", {63'd0, err}, {63'd0, bad});
    endtask

    task automatic add_case(string tag, logic [W-1:0] x, logic [W-1:0] y, logic bad);
        drive(x, y, bad);
        @(negedge clk);
        check_result(tag, x, y, bad);
    endtask

    // kind 0: propagate bit, 1: sum rail bit, 2: inverted rail bit, 3: carry copy 2
    task automatic fault_case(string tag, int kind, int pos, logic [W-1:0] x, logic [W-1:0] y);
        logic [W:0] r;
        r = ref_add(x, y);
        drive(x, y, 1'b0);
        case (kind)
            0: begin fv = (x ^ y) ^ (64'd1 << pos);    force u_scsa_adder.prop_w = fv; end
            1: begin fv = r[W-1:0] ^ (64'd1 << pos);   force u_scsa_adder.sum_w  = fv; end
            2: begin fv = ~r[W-1:0] ^ (64'd1 << pos);  force u_scsa_adder.sumn_w = fv; end
            default: begin fb = ~r[W];                 force u_scsa_adder.cout2_w = fb; end
        endcase
        @(negedge clk);
        chk(tag, "err under fault", {63'd0, err}, 64'd1);
        case (kind)
            0: release u_scsa_adder.prop_w;
            1: release u_scsa_adder.sum_w;
            2: release u_scsa_adder.sumn_w;
            default: release u_scsa_adder.cout2_w;
        endcase
        @(negedge clk);
        chk({tag, " R11"}, "err after release", {63'd0, err}, 64'd0);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int bnd [5] = '{8, 16, 28, 40, 52};
        logic [W-1:0] x, y;
        void'($urandom(32'd20240611));

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", "sum", sum, '0);
        chk("R9", "sumn", sumn, '1);
        chk("R9", "carries+err", {61'd0, c1, c2, err}, 64'd0);
        rst = 1'b0;

        // R1 R2 R3 R11: directed corner cases
        add_case("R1 zero", '0, '0, 1'b0);
        add_case("R3 allones+1", '1, 64'd1, 1'b0);
        add_case("R3 allones+allones", '1, '1, 1'b0);
        add_case("R2 alternating", {16{4'h5}}, {16{4'hA}}, 1'b0);
        add_case("R1 alt+alt", {16{4'hA}}, {16{4'hA}}, 1'b0);

        // R7: carries reaching and crossing each segment boundary
        foreach (bnd[i]) begin
            add_case("R7 ripple-to-boundary", (64'd1 << bnd[i]) - 64'd1, 64'd1, 1'b0);
            add_case("R7 cross-boundary", 64'd1 << (bnd[i] - 1), 64'd1 << (bnd[i] - 1), 1'b0);
            add_case("R7 full-chain", ~(64'd0) >> (64 - bnd[i]), ~(64'd0) << (bnd[i] - 1), 1'b0);
        end

        // R4: bad parity on a or b
        add_case("R4 bad parity", 64'h0123_4567_89AB_CDEF, 64'h0F0F_0000_FFFF_1234, 1'b1);
        add_case("R4 bad parity zero", '0, '0, 1'b1);

        // R10: outputs hold until the next rising edge
        add_case("R10 first", 64'd100, 64'd23, 1'b0);
        drive(64'hFFFF_0000_0000_0001, 64'd5, 1'b0);
        #1;
        chk("R10", "sum before edge", sum, 64'd123);
        @(negedge clk);
        check_result("R10 after edge", 64'hFFFF_0000_0000_0001, 64'd5, 1'b0);

        // Random operands, some with a corrupted parity bit
        for (int n = 0; n < 400; n++) begin
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            add_case((n % 9 == 4) ? "R4 random" : "R1 random", x, y, (n % 9 == 4));
        end

        // Fault injection: R8 propagate, R5 rails, R6 carry copy
        foreach (bnd[i]) begin
            fault_case("R8 propagate fault", 0, bnd[i] - 1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        end
        fault_case("R8 propagate fault msb", 0, 63, '1, 64'd1);
        fault_case("R5 sum rail fault", 1, 0, 64'd7, 64'd9);
        fault_case("R5 sum rail fault", 1, 40, '1, '1);
        fault_case("R5 inverted rail fault", 2, 17, 64'hDEAD_BEEF_0000_0001, 64'd3);
        fault_case("R6 carry copy fault", 3, 0, '1, 64'd1);
        fault_case("R6 carry copy fault", 3, 0, 64'd2, 64'd3);

        // R9: reset in mid-run with nonzero operands
        drive('1, '1, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid-run", "sum", sum, '0);
        chk("R9 mid-run", "sumn", sumn, '1);
        chk("R9 mid-run", "carries+err", {61'd0, c1, c2, err}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check_result("R1 after reset", '1, '1, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule